// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single-word requests from an internal port into accesses on an external 8-bit parallel memory bus. On that bus the low address byte and the data byte take turns on one shared set of lines. The high address byte has pins of its own. An address-latch-enable strobe tells an external transparent latch when to capture the low byte. Separate active-low read and write strobes then frame the data transfer. The shared lines are brought out as a drive value, a drive enable and an input sample, and the pad ring resolves them into the physical bidirectional bus.

Two kinds of external device with different speeds can share the bus. The address space is split at a programmable boundary on the three top address bits, and each of the two sectors gets its own two-bit wait-state code. The sector and its wait code are fixed when a request is accepted.

A keeper function holds the shared lines at the last value the controller drove whenever the controller is not driving them. Software can switch the keeper off.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is high and in the first idle cycle after it, `bus_ale`=0, `bus_rd_n`=1, `bus_wr_n`=1, `bus_ad_oe`=0, `req_ready`=0, `bus_ad_o`=0 and `bus_ah`=0.
- R2: A request seen while idle (`req_valid`=1 at a clock edge) starts an access in the next cycle. In that cycle `bus_ale`=1, `bus_ad_oe`=1, `bus_ad_o`=address bits 7:0 and `bus_ah`=address bits 15:8. `bus_ale` is high for exactly one cycle. In the cycle after it, `bus_ale`=0 and the low address is still driven. `bus_ah` keeps the address until the next access.
- R3: On a write (`req_we`=1), the write data is driven on `bus_ad_o` with `bus_ad_oe`=1 from the cycle after the address hold cycle until one cycle after `bus_wr_n` returns high. `bus_wr_n` is low only during the strobe cycles.
- R4: On a read, `bus_ad_oe`=0 from the cycle after the address hold cycle. `bus_rd_n` is low during the strobe cycles. `req_rdata` takes the value `bus_ad_i` has in the last cycle with `bus_rd_n` low, and it is valid while `req_ready`=1.
- R5: The wait code sets the number of strobe cycles: code 0 gives 1 cycle, code 1 gives 2, and codes 2 and 3 give 3. Code 3 also inserts one cycle between the address hold cycle and the strobe. In that cycle both strobes are high, and on a write the data is already driven.
- R6: If address bits 15:13 are below `cfg_bound` (unsigned), the access uses `cfg_ws_lo`. Otherwise it uses `cfg_ws_hi`. With `cfg_bound`=0 every address uses `cfg_ws_hi`.
- R7: `req_ready` is high for exactly one cycle: the cycle right after the last strobe cycle. The controller is idle in the cycle after that.
- R8: When `bus_ad_oe`=0, `bus_ad_hold` equals `cfg_keep_en`, and `bus_ad_o` keeps the last value driven with `bus_ad_oe`=1. `bus_ad_hold` is never 1 while `bus_ad_oe`=1.
- R9: `bus_rd_n` and `bus_wr_n` are never low together, and neither is low while `bus_ale`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, sampled only while idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Read data, valid with req_ready |
| cfg_bound | input | 3 | Sector boundary on address bits 15:13 |
| cfg_ws_lo | input | 2 | Wait code for the lower sector |
| cfg_ws_hi | input | 2 | Wait code for the upper sector |
| cfg_keep_en | input | 1 | Keeper enable |
| bus_ad_i | input | 8 | Sampled level of the shared address/data lines |
| bus_ad_o | output | 8 | Drive value for the shared lines |
| bus_ad_oe | output | 1 | Strong drive enable for the shared lines |
| bus_ad_hold | output | 1 | Weak hold of bus_ad_o on the shared lines |
| bus_ah | output | 8 | High address byte |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
Writes and reads are run with each of the four wait codes. The cycle-by-cycle comparison therefore separates the strobe widths of 1, 2 and 3 cycles, and it separates code 2 from code 3 by the extra gap cycle. On reads, the data lines carry the inverted value in every strobe cycle except the last one, so sampling one cycle too early or too late shows up. Sector selection is tried with addresses just below and at the boundary, and with a zero boundary, to show which of the two codes applies. The keeper is tried both enabled and disabled, to check that the hold flag follows the control bit while the driven value stays.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;

    typedef logic [1:0] ws_code_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_HOLD,
        PH_GAP,
        PH_STRB,
        PH_TAIL
    } phase_t;

    typedef struct packed {
        logic [1:0] strb_extra;  // added strobe cycles
        logic       gap;         // extra cycle after address phase
    } ws_plan_t;

    function automatic ws_plan_t ws_decode(input ws_code_t code);
        ws_plan_t p;
        case (code)
            2'd0:    p = '{strb_extra: 2'd0, gap: 1'b0};
            2'd1:    p = '{strb_extra: 2'd1, gap: 1'b0};
            2'd2:    p = '{strb_extra: 2'd2, gap: 1'b0};
            default: p = '{strb_extra: 2'd2, gap: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/xbus_sector_sel.sv
`timescale 1ns/1ps
module xbus_sector_sel
    import xbus_pkg::*;
#(
    parameter int SB = 3
) (
    input  logic [SB-1:0] top_bits,
    input  logic [SB-1:0] bound,
    input  ws_code_t      ws_lo,
    input  ws_code_t      ws_hi,
    output ws_code_t      ws_sel
);
    // below the boundary: lower sector; zero boundary never matches
    always_comb begin
        ws_sel = (top_bits < bound) ? ws_lo : ws_hi;
    end
endmodule

// File: rtl/xbus_seq.sv
`timescale 1ns/1ps
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    localparam int HW = AW - DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  ws_code_t      ws_code,
    input  logic [DW-1:0] ad_i,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          drv_en,
    output logic [DW-1:0] drv_val,
    output logic [HW-1:0] ah,
    output logic          ready,
    output logic [DW-1:0] rdata
);
    phase_t        phase;
    ws_plan_t      plan_q;
    logic [1:0]    cnt;
    logic          we_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            plan_q <= '0;
            cnt    <= '0;
            we_q   <= 1'b0;
            addr_q <= '0;
            wd_q   <= '0;
            rdata  <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (req_valid) begin
                    we_q   <= req_we;
                    addr_q <= req_addr;
                    wd_q   <= req_wdata;
                    plan_q <= ws_decode(ws_code);
                    phase  <= PH_ADDR;
                end
                PH_ADDR: phase <= PH_HOLD;
                PH_HOLD: begin
                    cnt   <= plan_q.strb_extra;
                    phase <= plan_q.gap ? PH_GAP : PH_STRB;
                end
                PH_GAP:  phase <= PH_STRB;
                PH_STRB: begin
                    if (cnt == 2'd0) begin
                        phase <= PH_TAIL;
                        if (!we_q) rdata <= ad_i;  // sample at strobe rise
                    end else begin
                        cnt <= cnt - 2'd1;
                    end
                end
                PH_TAIL: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    logic addr_phase, data_phase;
    always_comb begin
        addr_phase = (phase == PH_ADDR) || (phase == PH_HOLD);
        data_phase = we_q && ((phase == PH_GAP) || (phase == PH_STRB) || (phase == PH_TAIL));
        ale     = (phase == PH_ADDR);
        rd_n    = !((phase == PH_STRB) && !we_q);
        wr_n    = !((phase == PH_STRB) && we_q);
        drv_en  = addr_phase || data_phase;
        drv_val = addr_phase ? addr_q[DW-1:0] : wd_q;
        ah      = addr_q[AW-1:DW];
        ready   = (phase == PH_TAIL);
    end
endmodule

// File: rtl/xbus_keeper.sv
`timescale 1ns/1ps
module xbus_keeper #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          keep_en,
    input  logic          drv_en,
    input  logic [DW-1:0] drv_val,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe,
    output logic          ad_hold
);
    logic [DW-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst)         last_q <= '0;
        else if (drv_en) last_q <= drv_val;
    end

    always_comb begin
        ad_oe   = drv_en;
        ad_o    = drv_en ? drv_val : last_q;
        ad_hold = keep_en && !drv_en;
    end
endmodule

// File: rtl/xbus_ctrl.sv
`timescale 1ns/1ps
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int SB = 3,
    localparam int HW = AW - DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic [DW-1:0] req_rdata,
    input  logic [SB-1:0] cfg_bound,
    input  logic [1:0]    cfg_ws_lo,
    input  logic [1:0]    cfg_ws_hi,
    input  logic          cfg_keep_en,
    input  logic [DW-1:0] bus_ad_i,
    output logic [DW-1:0] bus_ad_o,
    output logic          bus_ad_oe,
    output logic          bus_ad_hold,
    output logic [HW-1:0] bus_ah,
    output logic          bus_ale,
    output logic          bus_rd_n,
    output logic          bus_wr_n
);
    ws_code_t      ws_sel;
    logic          drv_en;
    logic [DW-1:0] drv_val;

    xbus_sector_sel #(.SB(SB)) u_sect (
        .top_bits (req_addr[AW-1 -: SB]),
        .bound    (cfg_bound),
        .ws_lo    (cfg_ws_lo),
        .ws_hi    (cfg_ws_hi),
        .ws_sel   (ws_sel)
    );

    xbus_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ws_code   (ws_sel),
        .ad_i      (bus_ad_i),
        .ale       (bus_ale),
        .rd_n      (bus_rd_n),
        .wr_n      (bus_wr_n),
        .drv_en    (drv_en),
        .drv_val   (drv_val),
        .ah        (bus_ah),
        .ready     (req_ready),
        .rdata     (req_rdata)
    );

    xbus_keeper #(.DW(DW)) u_keep (
        .clk     (clk),
        .rst     (rst),
        .keep_en (cfg_keep_en),
        .drv_en  (drv_en),
        .drv_val (drv_val),
        .ad_o    (bus_ad_o),
        .ad_oe   (bus_ad_oe),
        .ad_hold (bus_ad_hold)
    );
endmodule

// File: rtl/xbus_ctrl_chk.sv
`timescale 1ns/1ps
module xbus_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_ale,
    input logic          bus_ad_oe,
    input logic          bus_ad_hold,
    input logic [DW-1:0] bus_ad_o,
    input logic          bus_rd_n,
    input logic          bus_wr_n,
    input logic          req_ready,
    input logic          cfg_keep_en
);
    p_ale_single_r2: assert property (@(posedge clk) disable iff (rst)
        bus_ale |=> !bus_ale);
    p_ale_drives_r2: assert property (@(posedge clk) disable iff (rst)
        bus_ale |-> bus_ad_oe);
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_ale) |-> (bus_ad_oe && bus_ad_o == $past(bus_ad_o)));
    p_write_driven_r3: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_n |-> bus_ad_oe);
    p_read_released_r4: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_n |-> !bus_ad_oe);
    p_ready_single_r7: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);
    p_ready_after_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> ($past(!bus_rd_n || !bus_wr_n) && bus_rd_n && bus_wr_n));
    p_hold_flag_r8: assert property (@(posedge clk) disable iff (rst)
        !bus_ad_oe |-> (bus_ad_hold == cfg_keep_en));
    p_hold_excl_r8: assert property (@(posedge clk) disable iff (rst)
        bus_ad_oe |-> !bus_ad_hold);
    p_keep_value_r8: assert property (@(posedge clk) disable iff (rst)
        (!bus_ad_oe && $past(!bus_ad_oe)) |-> $stable(bus_ad_o));
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(!bus_rd_n && !bus_wr_n));
    p_no_strobe_ale_r9: assert property (@(posedge clk) disable iff (rst)
        bus_ale |-> (bus_rd_n && bus_wr_n));
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_ale     (bus_ale),
    .bus_ad_oe   (bus_ad_oe),
    .bus_ad_hold (bus_ad_hold),
    .bus_ad_o    (bus_ad_o),
    .bus_rd_n    (bus_rd_n),
    .bus_wr_n    (bus_wr_n),
    .req_ready   (req_ready),
    .cfg_keep_en (cfg_keep_en)
);

// File: tb/test_xbus_ctrl.sv
`timescale 1ns/1ps
module test_xbus_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic [7:0]  req_rdata;
    logic [2:0]  cfg_bound = '0;
    logic [1:0]  cfg_ws_lo = '0, cfg_ws_hi = '0;
    logic        cfg_keep_en = 1'b1;
    logic [7:0]  bus_ad_i = '0;
    logic [7:0]  bus_ad_o, bus_ah;
    logic        bus_ad_oe, bus_ad_hold, bus_ale, bus_rd_n, bus_wr_n;

    int nvec = 0, nfail = 0, ncyc = 0;
    logic [7:0] last_drv = 8'h00;
    logic [7:0] last_ah = 8'h00;

    always #2 clk = ~clk;

    xbus_ctrl i_xbus_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .req_rdata(req_rdata), .cfg_bound(cfg_bound), .cfg_ws_lo(cfg_ws_lo),
        .cfg_ws_hi(cfg_ws_hi), .cfg_keep_en(cfg_keep_en), .bus_ad_i(bus_ad_i),
        .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_ad_hold(bus_ad_hold),
        .bus_ah(bus_ah), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
    );

    // compare the full output vector of one cycle
    task automatic expect_cyc(input string tag, input logic e_ale, input logic e_oe,
                              input logic e_hold, input logic e_rd, input logic e_wr,
                              input logic e_rdy, input logic [7:0] e_ado,
                              input logic [7:0] e_ah);
        logic [21:0] act, exp_v;
        act   = {bus_ale, bus_ad_oe, bus_ad_hold, bus_rd_n, bus_wr_n, req_ready, bus_ad_o, bus_ah};
        exp_v = {e_ale, e_oe, e_hold, e_rd, e_wr, e_rdy, e_ado, e_ah};
        nvec++;
        if (act !== exp_v) begin
            nfail++;
            $display("FAIL %s: ale/oe/hold/rd/wr/rdy/ado/ah got %h expected %h", tag, act, exp_v);
        end
        if (!bus_rd_n && !bus_wr_n) begin
            nfail++;
            $display("FAIL R9: both strobes low, got rd_n=%b wr_n=%b expected not both 0",
                     bus_rd_n, bus_wr_n);
        end
    endtask

    task automatic expect_idle(input string tag);
        expect_cyc(tag, 1'b0, 1'b0, cfg_keep_en, 1'b1, 1'b1, 1'b0, last_drv, last_ah);
    endtask

    task automatic access(input logic we, input logic [15:0] a,
                          input logic [7:0] wd, input logic [7:0] rv);
        logic [1:0] ws;
        int nstrb;
        logic [7:0] dval;
        ws    = (a[15:13] < cfg_bound) ? cfg_ws_lo : cfg_ws_hi;  // R6
        nstrb = (ws == 2'd0) ? 1 : (ws == 2'd1) ? 2 : 3;         // R5
        dval  = we ? wd : a[7:0];
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        last_ah = a[15:8];
        expect_cyc("R2 address cycle", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, a[7:0], a[15:8]);
        @(negedge clk);
        expect_cyc("R2 hold cycle", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, a[7:0], a[15:8]);
        if (ws == 2'd3) begin
            @(negedge clk);
            expect_cyc("R5 gap cycle", 1'b0, we, cfg_keep_en && !we, 1'b1, 1'b1, 1'b0,
                       dval, a[15:8]);
        end
        for (int k = 0; k < nstrb; k++) begin
            @(negedge clk);
            bus_ad_i = (k == nstrb - 1) ? rv : ~rv;
            expect_cyc(we ? "R3 write strobe" : "R4 read strobe", 1'b0, we,
                       cfg_keep_en && !we, we, !we, 1'b0, dval, a[15:8]);
        end
        @(negedge clk);
        bus_ad_i = 8'h5A;
        expect_cyc("R7 ready cycle", 1'b0, we, cfg_keep_en && !we, 1'b1, 1'b1, 1'b1,
                   dval, a[15:8]);
        if (!we) begin
            nvec++;
            if (req_rdata !== rv) begin
                nfail++;
                $display("FAIL R4: rdata got %h expected %h", req_rdata, rv);
            end
        end
        last_drv = dval;
        @(negedge clk);
        expect_idle("R7 idle after ready / R8 keeper");
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            expect_cyc("R1 in reset", 1'b0, 1'b0, cfg_keep_en, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
        end
        rst = 1'b0;
        @(negedge clk);
        expect_idle("R1 after reset");

        // all wait codes on writes and reads (R3 R4 R5), boundary 0 -> upper code
        for (int c = 0; c < 4; c++) begin
            cfg_ws_hi = c[1:0];
            cfg_ws_lo = ~c[1:0];
            access(1'b1, 16'h1234 + 16'(c), 8'hA0 + 8'(c), 8'h00);
            access(1'b0, 16'h8801 + 16'(c), 8'h00, 8'h3C + 8'(c));
        end

        // R6: sector split at 4; top bits 3 -> lower, 4 -> upper
        cfg_bound = 3'd4; cfg_ws_lo = 2'd3; cfg_ws_hi = 2'd0;
        access(1'b0, 16'h7FF0, 8'h00, 8'hC3);
        access(1'b1, 16'h8000, 8'h96, 8'h00);
        cfg_bound = 3'd0; cfg_ws_lo = 2'd3; cfg_ws_hi = 2'd1;
        access(1'b1, 16'h0042, 8'h11, 8'h00);   // R6 zero boundary -> upper code

        // R8: keeper off, value still held
        cfg_keep_en = 1'b0;
        @(negedge clk);
        expect_idle("R8 keeper disabled");
        access(1'b0, 16'hE0F1, 8'h00, 8'h77);
        access(1'b1, 16'h5555, 8'hAA, 8'h00);
        cfg_keep_en = 1'b1;
        @(negedge clk);
        expect_idle("R8 keeper re-enabled");

        repeat (3) begin
            @(negedge clk);
            expect_idle("R7 stays idle");
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    always @(posedge clk) begin
        ncyc++;
        if (ncyc > 20000) begin
            nfail++;
            $display("FAIL watchdog: got %0d cycles expected completion", ncyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule